// File: doc/BRIEF.md
# CAN Acceptance Filter

This block decides whether a received CAN frame should be kept. It compares the frame's identifier, RTR flag and, for standard frames, the leading data bytes against four programmed code bytes, under four programmed mask bytes. A mask bit of 1 makes the matching frame bit a don't-care. The receive path presents a frame's fields, holds them steady, and pulses `start`; one clock later `accept_valid` pulses together with the verdict on `accept`.

Two layouts are supported. In single layout the eight bytes form one long filter: a full 29-bit identifier for extended frames, or an 11-bit identifier followed by two data bytes for standard frames. In dual layout they form two shorter filters, A and B, and a frame that passes either one is kept. When the extended register set is switched off, the filter is bypassed and every frame is kept.

Code byte k sits at `acc_code[8k+7:8k]` and mask byte k at `acc_mask[8k+7:8k]`, for k = 0..3. Below, cK and mK name those bytes; "x matches c under m" means `((x ^ c) & ~m) == 0`.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, with `start` low, `accept_valid` and `accept` are both 0.
- R2: Single layout, extended frame: {ID28..21, ID20..13, ID12..5, ID4..0} must match {c0, c1, c2, c3[7:3]} under {m0, m1, m2, m3[7:3]}, and RTR must match c3[2] under m3[2]; c3[1:0] and m3[1:0] have no effect.
- R3: Single layout, standard frame: ID10..0 must match {c0, c1[7:5]} under {m0, m1[7:5]}, and RTR must match c1[4] under m1[4]; a failure here rejects the frame.
- R4: Single layout, standard frame passing R3 with RTR set or DLC 0 is accepted whatever its data bytes.
- R5: Single layout, standard data frame passing R3 with DLC 1 is accepted when data byte 0 matches c2 under m2; with DLC 2 or more, data byte 1 must also match c3 under m3.
- R6: Dual layout, extended frame: accepted when ID28..13 matches {c0, c1} under {m0, m1} (filter A) or {c2, c3} under {m2, m3} (filter B); RTR and ID12..0 have no effect.
- R7: Dual layout, standard frame, filter A: ID10..0 and RTR must match {c0, c1[7:4]} under {m0, m1[7:4]}, and data byte 0 must match {c1[3:0], c3[3:0]} under {m1[3:0], m3[3:0]}, regardless of DLC.
- R8: Dual layout, standard frame, filter B: ID10..0 and RTR matching {c2, c3[7:4]} under {m2, m3[7:4]} accepts the frame without any data check; passing either A or B accepts.
- R9: With `ext_regs_en` low, every frame is accepted.
- R10: `accept_valid` is high exactly in the cycle after a cycle with `start` high; `accept` is 0 whenever `accept_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Evaluate the presented frame this cycle |
| ext_regs_en | input | 1 | 1: filter active; 0: accept everything |
| dual_mode | input | 1 | 0: single layout; 1: dual layout |
| acc_code | input | 32 | Code bytes c0..c3, byte k at bits 8k+7:8k |
| acc_mask | input | 32 | Mask bytes m0..m3, same placement; 1 = don't care |
| frame_ext | input | 1 | 1: 29-bit identifier; 0: 11-bit in bits 10:0 |
| frame_rtr | input | 1 | Remote request flag |
| frame_dlc | input | 4 | Data length code |
| frame_id | input | 29 | Frame identifier |
| frame_d0 | input | 8 | First data byte |
| frame_d1 | input | 8 | Second data byte |
| accept_valid | output | 1 | Verdict valid, one cycle after start |
| accept | output | 1 | 1: keep the frame |

## Verification
The bench sweeps thousands of frames in every layout and frame kind, with identifiers and data often forced onto the code values so that both hits and near misses occur, and compares against an arithmetic model. Directed cases go after the DLC boundaries of the single standard data check: a design that always checks data byte 1 would wrongly reject DLC 1 frames, and one that checks data on RTR frames would drop remote requests. In dual layout it targets a frame that passes only filter B with mismatching data, which a design that applied the nibble check to both filters would reject, and extended frames differing only in ID12..0 or RTR, which a design comparing too many bits would reject. Bypass mode is checked with filters that reject everything.

// File: rtl/can_acf_pkg.sv
// Package: shared widths and the masked compare used by all filter parts.
// Assumes: a mask bit of 1 means the corresponding bit is a don't-care.
package can_acf_pkg;
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = 4;
    localparam int BANK_W   = BYTE_W * NBYTES;
    localparam int EXT_ID_W = 29;
    localparam int STD_ID_W = 11;
    localparam int DLC_W    = 4;

    // True when value and code agree on every bit the mask does not ignore.
    function automatic logic masked_eq32(input logic [31:0] value,
                                         input logic [31:0] code,
                                         input logic [31:0] mask);
        return ((value ^ code) & ~mask) == 32'd0;
    endfunction
endpackage

// File: rtl/acf_std_id_match.sv
// Module: compares an 11-bit standard identifier plus RTR against a pair of
// code bytes: identifier in hi byte and lo[7:5], RTR in lo[4].
// Assumes: lo[3:0] of code and mask belong to someone else and are ignored.
module acf_std_id_match
    import can_acf_pkg::*;
(
    input  logic [STD_ID_W-1:0] id,
    input  logic                rtr,
    input  logic [BYTE_W-1:0]   code_hi,
    input  logic [BYTE_W-1:0]   code_lo,
    input  logic [BYTE_W-1:0]   mask_hi,
    input  logic [BYTE_W-1:0]   mask_lo,
    output logic                hit
);
    logic [31:0] val_w, code_w, mask_w;
    logic [3:0]  unused_lo;

    // Pack identifier and RTR into one compare word.
    always_comb begin
        val_w  = {20'd0, id, rtr};
        code_w = {20'd0, code_hi, code_lo[7:4]};
        mask_w = {20'd0, mask_hi, mask_lo[7:4]};
        hit    = masked_eq32(val_w, code_w, mask_w);
    end

    assign unused_lo = code_lo[3:0] ^ mask_lo[3:0];
endmodule

// File: rtl/acf_single.sv
// Module: single-layout filter. All four code/mask bytes form one filter:
// a 29-bit identifier with RTR for extended frames, or an 11-bit identifier
// with RTR followed by up to two data bytes for standard frames.
// Assumes: inputs are steady while the result is used.
module acf_single
    import can_acf_pkg::*;
(
    input  logic [BANK_W-1:0]   code,
    input  logic [BANK_W-1:0]   mask,
    input  logic                ext,
    input  logic                rtr,
    input  logic [DLC_W-1:0]    dlc,
    input  logic [EXT_ID_W-1:0] id,
    input  logic [BYTE_W-1:0]   d0,
    input  logic [BYTE_W-1:0]   d1,
    output logic                hit
);
    logic [BYTE_W-1:0] c [NBYTES];
    logic [BYTE_W-1:0] m [NBYTES];
    logic ext_hit, std_id_hit, d0_hit, d1_hit, std_hit;

    // Split the packed banks into bytes.
    for (genvar k = 0; k < NBYTES; k++) begin : g_split
        assign c[k] = code[k*BYTE_W +: BYTE_W];
        assign m[k] = mask[k*BYTE_W +: BYTE_W];
    end

    // Extended frame: full identifier plus RTR at bit 2 of byte 3.
    always_comb begin
        ext_hit = masked_eq32({2'b00, id, rtr},
                              {2'b00, c[0], c[1], c[2], c[3][7:3], c[3][2]},
                              {2'b00, m[0], m[1], m[2], m[3][7:3], m[3][2]});
    end

    acf_std_id_match u_std_id (
        .id      (id[STD_ID_W-1:0]),
        .rtr     (rtr),
        .code_hi (c[0]),
        .code_lo (c[1]),
        .mask_hi (m[0]),
        .mask_lo (m[1]),
        .hit     (std_id_hit)
    );

    // Data byte compares against bytes 2 and 3.
    always_comb begin
        d0_hit = masked_eq32({24'd0, d0}, {24'd0, c[2]}, {24'd0, m[2]});
        d1_hit = masked_eq32({24'd0, d1}, {24'd0, c[3]}, {24'd0, m[3]});
    end

    // Standard frame: identifier first, then as many data bytes as present.
    always_comb begin
        if (!std_id_hit)
            std_hit = 1'b0;
        else if (rtr || dlc == '0)
            std_hit = 1'b1;
        else if (!d0_hit)
            std_hit = 1'b0;
        else if (dlc == DLC_W'(1))
            std_hit = 1'b1;
        else
            std_hit = d1_hit;
    end

    assign hit = ext ? ext_hit : std_hit;

    // R4: a remote request that passes the identifier check is never refused.
    always_comb begin
        a_r4_rtr_passes: assert (!(!ext && rtr && std_id_hit) || hit);
    end
endmodule

// File: rtl/acf_dual.sv
// Module: dual-layout filter. Bytes 0,1 (code and mask) form filter A and
// bytes 2,3 form filter B. Extended frames use ID28..13 only; standard
// frames use identifier and RTR, and filter A also checks data byte 0 against
// a byte assembled from the low nibbles of bytes 1 and 3.
// Assumes: inputs are steady while the result is used.
module acf_dual
    import can_acf_pkg::*;
#(
    parameter int NBANKS = 2
) (
    input  logic [BANK_W-1:0]   code,
    input  logic [BANK_W-1:0]   mask,
    input  logic                ext,
    input  logic                rtr,
    input  logic [EXT_ID_W-1:0] id,
    input  logic [BYTE_W-1:0]   d0,
    output logic                hit
);
    localparam int HI_ID_W = 2 * BYTE_W;
    localparam int HI_ID_LSB = EXT_ID_W - HI_ID_W;

    logic [BYTE_W-1:0] c [NBYTES];
    logic [BYTE_W-1:0] m [NBYTES];
    logic [NBANKS-1:0] ext_hit, std_id_hit;
    logic              d0_hit;
    logic [1:0]        unused_id;

    // Split the packed banks into bytes.
    for (genvar k = 0; k < NBYTES; k++) begin : g_split
        assign c[k] = code[k*BYTE_W +: BYTE_W];
        assign m[k] = mask[k*BYTE_W +: BYTE_W];
    end

    // One identifier comparator pair per filter bank.
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        // Extended: upper 16 identifier bits against the bank's two bytes.
        always_comb begin
            ext_hit[b] = masked_eq32({16'd0, id[EXT_ID_W-1:HI_ID_LSB]},
                                     {16'd0, c[2*b], c[2*b+1]},
                                     {16'd0, m[2*b], m[2*b+1]});
        end

        acf_std_id_match u_std_id (
            .id      (id[STD_ID_W-1:0]),
            .rtr     (rtr),
            .code_hi (c[2*b]),
            .code_lo (c[2*b+1]),
            .mask_hi (m[2*b]),
            .mask_lo (m[2*b+1]),
            .hit     (std_id_hit[b])
        );
    end

    // Filter A data check on byte 0, nibbles taken from bytes 1 and 3.
    always_comb begin
        d0_hit = masked_eq32({24'd0, d0},
                             {24'd0, c[1][3:0], c[3][3:0]},
                             {24'd0, m[1][3:0], m[3][3:0]});
    end

    // Either filter accepts.
    always_comb begin
        if (ext)
            hit = |ext_hit;
        else
            hit = (std_id_hit[0] && d0_hit) || std_id_hit[1];
    end

    assign unused_id = id[STD_ID_W+1:STD_ID_W];

    // R8: filter B on a standard frame needs no data check.
    always_comb begin
        a_r8_bank_b_alone: assert (!(!ext && std_id_hit[1]) || hit);
    end
endmodule

// File: rtl/can_accept_filter.sv
// Module: top of the CAN acceptance filter. Selects the single or dual
// layout result, forces acceptance when the extended register set is off,
// and registers the verdict with a one-cycle valid pulse.
// Assumes: frame fields and configuration are held steady in the start cycle.
module can_accept_filter
    import can_acf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        ext_regs_en,
    input  logic        dual_mode,
    input  logic [31:0] acc_code,
    input  logic [31:0] acc_mask,
    input  logic        frame_ext,
    input  logic        frame_rtr,
    input  logic [3:0]  frame_dlc,
    input  logic [28:0] frame_id,
    input  logic [7:0]  frame_d0,
    input  logic [7:0]  frame_d1,
    output logic        accept_valid,
    output logic        accept
);
    logic single_hit, dual_hit, verdict;

    acf_single u_single (
        .code (acc_code),
        .mask (acc_mask),
        .ext  (frame_ext),
        .rtr  (frame_rtr),
        .dlc  (frame_dlc),
        .id   (frame_id),
        .d0   (frame_d0),
        .d1   (frame_d1),
        .hit  (single_hit)
    );

    acf_dual #(.NBANKS(2)) u_dual (
        .code (acc_code),
        .mask (acc_mask),
        .ext  (frame_ext),
        .rtr  (frame_rtr),
        .id   (frame_id),
        .d0   (frame_d0),
        .hit  (dual_hit)
    );

    // Pick the layout and apply the bypass.
    always_comb begin
        if (!ext_regs_en)
            verdict = 1'b1;
        else
            verdict = dual_mode ? dual_hit : single_hit;
    end

    // Register the verdict; hold accept low outside the valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_valid <= 1'b0;
            accept       <= 1'b0;
        end else begin
            accept_valid <= start;
            accept       <= start & verdict;
        end
    end

    // R10: a start is answered on the next cycle.
    a_r10_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> accept_valid);
    // R10: no verdict without a start the cycle before.
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !accept_valid && !accept);
    // R9: bypass accepts everything.
    a_r9_bypass_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ext_regs_en) |=> accept);
    // R2: an exact single-layout extended match is accepted.
    a_r2_single_ext_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ext_regs_en && !dual_mode && frame_ext &&
         frame_id == {acc_code[7:0], acc_code[15:8], acc_code[23:16], acc_code[31:27]} &&
         frame_rtr == acc_code[26]) |=> accept);
    // R6: an exact filter-A dual-layout extended match is accepted.
    a_r6_dual_ext_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ext_regs_en && dual_mode && frame_ext &&
         frame_id[28:13] == {acc_code[7:0], acc_code[15:8]}) |=> accept);
endmodule

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ext_regs_en = 1'b0;
    logic        dual_mode = 1'b0;
    logic [31:0] acc_code = '0;
    logic [31:0] acc_mask = '0;
    logic        frame_ext = 1'b0;
    logic        frame_rtr = 1'b0;
    logic [3:0]  frame_dlc = '0;
    logic [28:0] frame_id = '0;
    logic [7:0]  frame_d0 = '0;
    logic [7:0]  frame_d1 = '0;
    logic        accept_valid, accept;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    can_accept_filter dut (.*);

    function automatic bit fok(input logic [31:0] v, input logic [31:0] c, input logic [31:0] m);
        return ((v ^ c) & ~m) == 32'd0;
    endfunction

    function automatic bit cb(input logic [31:0] w, input int k);
        return 1'b0;
    endfunction

    // Arithmetic model of the requirements R2..R9.
    function automatic bit model(input bit en, input bit dual, input bit ext, input bit rtr,
                                 input logic [3:0] dlc, input logic [28:0] id,
                                 input logic [7:0] d0, input logic [7:0] d1,
                                 input logic [31:0] code, input logic [31:0] mask);
        logic [7:0] c0, c1, c2, c3, m0, m1, m2, m3;
        bit a, b;
        {c3, c2, c1, c0} = code;
        {m3, m2, m1, m0} = mask;
        if (!en) return 1'b1;
        if (!dual && ext)
            return fok({2'b0, id, rtr}, {2'b0, c0, c1, c2, c3[7:3], c3[2]},
                       {2'b0, m0, m1, m2, m3[7:3], m3[2]});
        if (!dual) begin
            if (!fok({20'd0, id[10:0], rtr}, {20'd0, c0, c1[7:4]}, {20'd0, m0, m1[7:4]})) return 1'b0;
            if (rtr || dlc == 0) return 1'b1;
            if (!fok({24'd0, d0}, {24'd0, c2}, {24'd0, m2})) return 1'b0;
            if (dlc == 1) return 1'b1;
            return fok({24'd0, d1}, {24'd0, c3}, {24'd0, m3});
        end
        if (ext)
            return fok({16'd0, id[28:13]}, {16'd0, c0, c1}, {16'd0, m0, m1}) ||
                   fok({16'd0, id[28:13]}, {16'd0, c2, c3}, {16'd0, m2, m3});
        a = fok({20'd0, id[10:0], rtr}, {20'd0, c0, c1[7:4]}, {20'd0, m0, m1[7:4]}) &&
            fok({24'd0, d0}, {24'd0, c1[3:0], c3[3:0]}, {24'd0, m1[3:0], m3[3:0]});
        b = fok({20'd0, id[10:0], rtr}, {20'd0, c2, c3[7:4]}, {20'd0, m2, m3[7:4]});
        return a || b;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b (id=%h ext=%0b rtr=%0b dlc=%0d d0=%h d1=%h dual=%0b en=%0b)",
                     tag, act, exp, frame_id, frame_ext, frame_rtr, frame_dlc, frame_d0, frame_d1,
                     dual_mode, ext_regs_en);
        end
    endtask

    // Present a frame, pulse start, check the verdict the next cycle and
    // that valid drops the cycle after.
    task automatic run_frame(input string tag, input bit exp, input bit chk_drop);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " valid"}, accept_valid, 1'b1);
        check(tag, accept, exp);
        if (chk_drop) begin
            @(negedge clk);
            check("R10 valid drop", accept_valid, 1'b0);
            check("R10 accept low", accept, 1'b0);
        end
    endtask

    task automatic set_frame(input bit ext, input bit rtr, input logic [3:0] dlc,
                             input logic [28:0] id, input logic [7:0] d0, input logic [7:0] d1);
        frame_ext = ext; frame_rtr = rtr; frame_dlc = dlc;
        frame_id = id; frame_d0 = d0; frame_d1 = d1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", accept_valid, 1'b0);
        check("R1 accept", accept, 1'b0);

        // R9: bypass with a filter that rejects everything else
        ext_regs_en = 1'b0; dual_mode = 1'b0;
        acc_code = 32'hFFFF_FFFF; acc_mask = 32'h0;
        set_frame(1'b0, 1'b0, 4'd2, 29'h0, 8'h00, 8'h00);
        run_frame("R9 bypass", 1'b1, 1'b1);

        // Directed single-layout standard cases. c0=0xA5, c1: id[2:0]=3,rtr=0
        ext_regs_en = 1'b1; dual_mode = 1'b0;
        acc_code = {8'h3C, 8'h5A, 8'h60, 8'hA5};
        acc_mask = 32'h0;
        // R4: RTR with mismatching data accepted (rtr code bit 0 -> use mask)
        acc_mask = {8'h00, 8'h00, 8'h10, 8'h00};
        set_frame(1'b0, 1'b1, 4'd8, {18'd0, 8'hA5, 3'd3}, 8'h00, 8'h00);
        run_frame("R4 rtr skip data", 1'b1, 1'b0);
        // R4: DLC 0 data frame accepted
        set_frame(1'b0, 1'b0, 4'd0, {18'd0, 8'hA5, 3'd3}, 8'h00, 8'h00);
        run_frame("R4 dlc0", 1'b1, 1'b0);
        // R3: identifier mismatch rejects
        set_frame(1'b0, 1'b1, 4'd0, {18'd0, 8'hA4, 3'd3}, 8'h00, 8'h00);
        run_frame("R3 id miss", 1'b0, 1'b0);
        // R5: DLC 1 with good d0, bad d1 accepted
        set_frame(1'b0, 1'b0, 4'd1, {18'd0, 8'hA5, 3'd3}, 8'h5A, 8'h00);
        run_frame("R5 dlc1", 1'b1, 1'b0);
        // R5: DLC 2 with bad d1 rejected
        set_frame(1'b0, 1'b0, 4'd2, {18'd0, 8'hA5, 3'd3}, 8'h5A, 8'h00);
        run_frame("R5 dlc2 d1 miss", 1'b0, 1'b0);
        // R5: DLC 2 with both data bytes matching accepted
        set_frame(1'b0, 1'b0, 4'd2, {18'd0, 8'hA5, 3'd3}, 8'h5A, 8'h3C);
        run_frame("R5 dlc2 hit", 1'b1, 1'b0);
        // R5: DLC 1 with bad d0 rejected
        set_frame(1'b0, 1'b0, 4'd1, {18'd0, 8'hA5, 3'd3}, 8'h5B, 8'h3C);
        run_frame("R5 dlc1 d0 miss", 1'b0, 1'b0);

        // R2: extended exact, then RTR flip (care) rejects, c3[1:0] ignored
        acc_code = {8'b10101_1_11, 8'h77, 8'h66, 8'h55};
        acc_mask = 32'h0;
        set_frame(1'b1, 1'b1, 4'd0, {8'h55, 8'h66, 8'h77, 5'b10101}, 8'h00, 8'h00);
        run_frame("R2 ext exact", 1'b1, 1'b0);
        set_frame(1'b1, 1'b0, 4'd0, {8'h55, 8'h66, 8'h77, 5'b10101}, 8'h00, 8'h00);
        run_frame("R2 ext rtr miss", 1'b0, 1'b0);
        set_frame(1'b1, 1'b1, 4'd0, {8'h55, 8'h66, 8'h77, 5'b10100}, 8'h00, 8'h00);
        run_frame("R2 ext id4..0 miss", 1'b0, 1'b0);

        // Dual layout directed cases
        dual_mode = 1'b1;
        // R6: ID12..0 and RTR ignored, match on filter B only
        acc_code = {8'h34, 8'h12, 8'hFF, 8'hFF};
        acc_mask = 32'h0;
        set_frame(1'b1, 1'b1, 4'd3, {8'h12, 8'h34, 13'h1ABC}, 8'h00, 8'h00);
        run_frame("R6 bank B ext", 1'b1, 1'b0);
        set_frame(1'b1, 1'b0, 4'd3, {8'h12, 8'h35, 13'h0}, 8'h00, 8'h00);
        run_frame("R6 ext miss", 1'b0, 1'b0);
        // R7 / R8: filter A id hit with data mismatch, B misses -> reject
        // c0=0x81,c1={id=2,rtr=0,nib=0x9}; c2=0x42,c3={id=5,rtr=1,nib=0xC}
        acc_code = {8'b101_1_1100, 8'h42, 8'b010_0_1001, 8'h81};
        set_frame(1'b0, 1'b0, 4'd0, {18'd0, 8'h81, 3'd2}, 8'h9C, 8'h00);
        run_frame("R7 A hit", 1'b1, 1'b0);
        set_frame(1'b0, 1'b0, 4'd0, {18'd0, 8'h81, 3'd2}, 8'h9D, 8'h00);
        run_frame("R7 A data miss", 1'b0, 1'b0);
        set_frame(1'b0, 1'b1, 4'd0, {18'd0, 8'h42, 3'd5}, 8'h00, 8'h00);
        run_frame("R8 B only", 1'b1, 1'b1);

        // Sweeps over all four active combinations plus bypass
        for (int mode = 0; mode < 5; mode++) begin
            for (int n = 0; n < 3000; n++) begin
                logic [31:0] c, m;
                logic [28:0] id;
                logic [7:0]  d0, d1;
                bit ext, rtr, en, dl;
                logic [3:0] dlc;
                string tag;
                c = $urandom; m = $urandom & $urandom & $urandom;
                en  = (mode != 4);
                dl  = (mode == 2 || mode == 3);
                ext = (mode == 1 || mode == 3) ? 1'b1 : (mode == 4 ? $urandom_range(0, 1) : 1'b0);
                rtr = $urandom_range(0, 3) == 0;
                dlc = 4'($urandom_range(0, 8));
                id  = $urandom; d0 = $urandom; d1 = $urandom;
                if ($urandom_range(0, 3) != 0) begin
                    if (!dl && ext) begin id = {c[7:0], c[15:8], c[23:16], c[31:27]}; rtr = c[26]; end
                    else if (!dl) begin id[10:0] = {c[7:0], c[15:13]}; rtr = c[12]; end
                    else if (ext) begin
                        id[28:13] = $urandom_range(0, 1) ? {c[7:0], c[15:8]} : {c[23:16], c[31:24]};
                    end else if ($urandom_range(0, 1)) begin
                        id[10:0] = {c[7:0], c[15:13]}; rtr = c[12];
                    end else begin
                        id[10:0] = {c[23:16], c[31:29]}; rtr = c[28];
                    end
                    if ($urandom_range(0, 1)) d0 = dl ? {c[11:8], c[27:24]} : c[23:16];
                    if ($urandom_range(0, 1)) d1 = c[31:24];
                    if ($urandom_range(0, 2) == 0) id[$urandom_range(0, 28)] ^= 1'b1;
                end
                case (mode)
                    0: tag = "R3/R5 single std sweep";
                    1: tag = "R2 single ext sweep";
                    2: tag = "R7/R8 dual std sweep";
                    3: tag = "R6 dual ext sweep";
                    default: tag = "R9 bypass sweep";
                endcase
                ext_regs_en = en; dual_mode = dl; acc_code = c; acc_mask = m;
                set_frame(ext, rtr, dlc, id, d0, d1);
                run_frame(tag, model(en, dl, ext, rtr, dlc, id, d0, d1, c, m), 1'b0);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule